// File: doc/BRIEF.md
# Byte-Addressed SPI Memory Slave with Block Write Protection

This block is an SPI slave (clock idle low, data sampled on the rising clock edge and shifted out on the falling edge) that gives a host access to an internal byte-wide register array. The host frames each command with an active-low chip select. The first byte of a frame is the command code. Commands can set or clear a write-enable flag, read or load a small status byte, or start a read or write burst. A burst carries a two-byte start address and then any number of data bytes. The address advances by one after each byte and wraps from the top of the array back to zero.

Writes run at the speed of the serial clock. There is no page buffer. Each received byte is stored in the array in the system clock cycle after its eighth bit is seen. A write is allowed only if the enable flag was set by an earlier frame. A two-bit protection code in the status byte fences off none, the top quarter, the top half or all of the array. The write burst stops for good as soon as its current address falls inside the fenced region. The serial pins are sampled into the system clock domain through synchronizers, so the serial clock must be several system clocks per half period. The serial output is described by a data bit and a separate output-enable, which is low whenever the slave is not shifting data out.

Top module: `nvspi_ctrl`

## Requirements
- R1: The status byte reads as 0x40 | (protection code << 2) | (enable flag << 1). Bits 7..4 are always 0100 and bit 0 is always 0. After reset it reads 0x40.
- R2: Command 06h sets the write-enable flag and command 04h clears it. Command 05h shifts out the status byte.
- R3: Command 01h loads bits 3..2 of its data byte into the protection code only while the enable flag is set. All other bits of that data byte, including bit 1, have no effect.
- R4: The enable flag clears when chip select rises at the end of a frame whose command was 02h or 01h.
- R5: A write frame (02h) issued while the enable flag is clear stores nothing.
- R6: Commands 02h and 03h are followed by a high address byte and then a low address byte. The address is the low ADDR_W bits of these two bytes. Each later data byte goes to the next incrementing address and is committed once its eighth bit has arrived.
- R7: After the last location (2^ADDR_W - 1), the burst address continues at 0, for both reads and writes.
- R8: A read frame (03h) returns the stored bytes MSB first. Each bit is driven after a falling clock edge, ready for the next rising edge.
- R9: Protection code 00 fences nothing. Code 01 fences addresses in the top quarter, code 10 fences the top half, and code 11 fences the whole array.
- R10: A write stores nothing at a fenced address. Once the current address is fenced, no later byte of that frame is stored, even if the address later wraps into unfenced space.
- R11: Any other command code is ignored, and so are the bytes that follow it, until chip select rises. Such a frame leaves the flag, the code and the array unchanged.
- R12: The output-enable is low except during the data phase of a status or array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select framing each command |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave |
| spi_miso_oe | output | 1 | High while spi_miso is to be driven onto the line |

## Verification
One write burst starts near the top of the array and covers every location, so it also wraps. A full read of the array then compares each byte with its arithmetic pattern, which separates address-order and wrap mistakes from bit-order mistakes. Short bursts that cross the quarter and half boundaries under each protection code show whether the fence is tested on every incremented address and whether the abort holds. Another burst starts inside the fence and wraps into free space, which tells an abort that holds apart from a per-byte check. Enable-flag, status-write and unknown-command sequences are judged through status reads, so the fixed bits and the self-clearing flag are seen at the pins.

// File: rtl/nvspi_pkg.sv
package nvspi_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    S_OPC, S_ADH, S_ADL, S_WDATA, S_RDATA, S_STAT, S_WSR, S_SKIP
  } state_t;
endpackage

// File: rtl/nvspi_sync.sv
module nvspi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic si_i,
  output logic cs_act,
  output logic cs_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  logic [STAGES:0]   sck_p;
  logic [STAGES:0]   cs_p;
  logic [STAGES-1:0] si_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[STAGES-1:0], sck_i};
      cs_p  <= {cs_p[STAGES-1:0], cs_n_i};
      si_p  <= {si_p[STAGES-2:0], si_i};
    end
  end

  assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign cs_act   = ~cs_p[STAGES-1];
  assign cs_end   = cs_p[STAGES-1] & ~cs_p[STAGES];
  assign si_s     = si_p[STAGES-1];
endmodule

// File: rtl/nvspi_guard.sv
module nvspi_guard #(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        code,
  output logic              hit
);
  always_comb begin
    unique case (code)
      2'b00:   hit = 1'b0;
      2'b01:   hit = addr[ADDR_W-1] & addr[ADDR_W-2];
      2'b10:   hit = addr[ADDR_W-1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/nvspi_array.sv
module nvspi_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvspi_ctrl.sv
module nvspi_ctrl
  import nvspi_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int HI_W = ADDR_W - 8;

  logic cs_act, cs_end, sck_rise, sck_fall, si_s;

  nvspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck),
    .si_i(spi_mosi), .cs_act(cs_act), .cs_end(cs_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
  );

  state_t            st_q;
  logic [2:0]        bcnt_q;
  logic [6:0]        sh_q;
  logic [7:0]        txb_q;
  logic              so_q, oe_q;
  logic              wel_q, clr_pend_q, is_rd_q;
  logic [1:0]        bp_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_q;

  logic              byte_done;
  logic [7:0]        rx_byte;
  logic [ADDR_W-1:0] rx_addr, rd_addr;
  logic [7:0]        rd_data, status;
  logic              prot_hit, mem_we;

  assign byte_done = cs_act & sck_rise & (bcnt_q == 3'd7);
  assign rx_byte   = {sh_q, si_s};
  assign rx_addr   = {hi_q, rx_byte};
  assign rd_addr   = (st_q == S_ADL) ? rx_addr : ADDR_W'(addr_q + 1'b1);
  assign status    = {4'b0100, bp_q, wel_q, 1'b0};

  nvspi_guard #(.ADDR_W(ADDR_W)) u_guard (
    .addr(addr_q), .code(bp_q), .hit(prot_hit)
  );

  assign mem_we = byte_done & (st_q == S_WDATA) & wel_q & ~prot_hit;

  nvspi_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(addr_q), .wdata(rx_byte),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_OPC;
      bcnt_q     <= '0;
      sh_q       <= '0;
      txb_q      <= '0;
      so_q       <= 1'b0;
      oe_q       <= 1'b0;
      wel_q      <= 1'b0;
      clr_pend_q <= 1'b0;
      is_rd_q    <= 1'b0;
      bp_q       <= 2'b00;
      hi_q       <= '0;
      addr_q     <= '0;
    end else if (!cs_act) begin
      st_q       <= S_OPC;
      bcnt_q     <= '0;
      oe_q       <= 1'b0;
      clr_pend_q <= 1'b0;
      if (cs_end && clr_pend_q) wel_q <= 1'b0;
    end else begin
      if (sck_rise) begin
        sh_q   <= rx_byte[6:0];
        bcnt_q <= bcnt_q + 3'd1;
      end
      if (sck_fall && (st_q == S_RDATA || st_q == S_STAT)) begin
        so_q <= txb_q[~bcnt_q];
        oe_q <= 1'b1;
      end
      if (byte_done) begin
        unique case (st_q)
          S_OPC: begin
            unique case (rx_byte)
              OP_WREN: begin wel_q <= 1'b1; st_q <= S_SKIP; end
              OP_WRDI: begin wel_q <= 1'b0; st_q <= S_SKIP; end
              OP_RDSR: begin txb_q <= status; st_q <= S_STAT; end
              OP_WRSR: begin clr_pend_q <= 1'b1; st_q <= S_WSR; end
              OP_WRITE: begin
                clr_pend_q <= 1'b1;
                is_rd_q    <= 1'b0;
                st_q       <= S_ADH;
              end
              OP_READ: begin is_rd_q <= 1'b1; st_q <= S_ADH; end
              default: st_q <= S_SKIP;
            endcase
          end
          S_ADH: begin
            hi_q <= rx_byte[HI_W-1:0];
            st_q <= S_ADL;
          end
          S_ADL: begin
            addr_q <= rx_addr;
            if (is_rd_q) begin
              txb_q <= rd_data;
              st_q  <= S_RDATA;
            end else begin
              st_q <= wel_q ? S_WDATA : S_SKIP;
            end
          end
          S_WDATA: begin
            if (wel_q && !prot_hit) addr_q <= ADDR_W'(addr_q + 1'b1);
            else                    st_q   <= S_SKIP;
          end
          S_RDATA: begin
            addr_q <= ADDR_W'(addr_q + 1'b1);
            txb_q  <= rd_data;
          end
          S_STAT: txb_q <= status;
          S_WSR: begin
            if (wel_q) bp_q <= rx_byte[3:2];
            st_q <= S_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign spi_miso    = so_q;
  assign spi_miso_oe = oe_q;
endmodule

// File: rtl/nvspi_ctrl_chk.sv
module nvspi_ctrl_chk
  import nvspi_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              byte_done,
  input logic              mem_we,
  input logic [ADDR_W-1:0] addr_q,
  input logic [1:0]        bp_q,
  input logic              wel_q,
  input logic              oe,
  input state_t            st
);
  logic fenced;
  assign fenced = (bp_q == 2'b11) ||
                  (bp_q == 2'b10 && addr_q >= ADDR_W'(1 << (ADDR_W - 1))) ||
                  (bp_q == 2'b01 && addr_q >= ADDR_W'(3 << (ADDR_W - 2)));

  // R12
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !oe);

  // R12
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (st == S_RDATA || st == S_STAT));

  // R10
  no_fenced_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!fenced && wel_q));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

  // R3
  code_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp_q) |-> ($past(wel_q) && $past(byte_done)));

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(byte_done));
endmodule

bind nvspi_ctrl nvspi_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_done(byte_done),
  .mem_we(mem_we), .addr_q(addr_q), .bp_q(bp_q), .wel_q(wel_q),
  .oe(spi_miso_oe), .st(st_q)
);

// File: tb/nvspi_ctrl_tb.sv
module nvspi_ctrl_tb;
  localparam int AW   = 9;
  localparam int NLOC = 1 << AW;
  localparam time HALF = 60ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [NLOC];
  logic       wel_m = 1'b0;
  logic [1:0] bp_m = 2'b00;

  always #5ns clk = ~clk;

  nvspi_ctrl #(.ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  function automatic logic [7:0] pat(int a, int seed);
    return 8'((a * 37 + seed) & 255);
  endfunction

  function automatic bit fenced(int a, logic [1:0] code);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return a >= (NLOC * 3) / 4;
      2'b10:   return a >= NLOC / 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      #HALF;
      rx[i] = miso;
      sck = 1'b1;
      #HALF;
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    #HALF;
  endtask

  task automatic desel();
    #HALF;
    cs_n = 1'b1;
    #(HALF * 3);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    sel();
    xfer(op, r);
    desel();
    if (op == 8'h06) wel_m = 1'b1;
    if (op == 8'h04) wel_m = 1'b0;
  endtask

  task automatic rd_status(input string req);
    logic [7:0] r, exp;
    sel();
    xfer(8'h05, r);
    xfer(8'h00, r);
    check(miso_oe === 1'b1, "R12 oe during status", int'(miso_oe), 1);
    desel();
    exp = 8'h40 | {4'b0, bp_m, 2'b0} | {6'b0, wel_m, 1'b0};
    check(r === exp, req, r, exp);
  endtask

  task automatic wr_status(input logic [7:0] v);
    logic [7:0] r;
    sel();
    xfer(8'h01, r);
    xfer(v, r);
    desel();
    if (wel_m) bp_m = v[3:2];
    wel_m = 1'b0;
  endtask

  task automatic wr_burst(input int start, input int n, input int seed);
    logic [7:0] r;
    bit stop;
    int a;
    stop = !wel_m;
    sel();
    xfer(8'h02, r);
    xfer(8'(start >> 8), r);
    xfer(8'(start), r);
    for (int i = 0; i < n; i++) begin
      a = (start + i) % NLOC;
      xfer(pat(a, seed), r);
      if (!stop && fenced(a, bp_m)) stop = 1'b1;
      if (!stop) model[a] = pat(a, seed);
    end
    desel();
    wel_m = 1'b0;
  endtask

  task automatic rd_burst(input int start, input int n, input string req);
    logic [7:0] r;
    int a;
    sel();
    xfer(8'h03, r);
    xfer(8'(start >> 8), r);
    xfer(8'(start), r);
    for (int i = 0; i < n; i++) begin
      a = (start + i) % NLOC;
      xfer(8'h00, r);
      check(r === model[a], req, r, model[a]);
    end
    check(miso_oe === 1'b1, "R12 oe during read", int'(miso_oe), 1);
    desel();
    check(miso_oe === 1'b0, "R12 oe after frame", int'(miso_oe), 0);
  endtask

  initial begin
    logic [7:0] r;
    #23ns;
    rst_n = 1'b1;
    #100ns;
    check(miso_oe === 1'b0, "R12 idle", int'(miso_oe), 0);
    rd_status("R1 reset status");

    cmd(8'h06);
    rd_status("R2 flag set");
    cmd(8'h04);
    rd_status("R2 flag clear");
    wr_status(8'h0C);
    rd_status("R3 status write without flag");

    // R6 R7: fill the whole array with a burst that wraps
    cmd(8'h06);
    wr_burst(NLOC - 16, NLOC, 11);
    rd_status("R4 flag cleared after write");
    rd_burst(0, NLOC, "R6 R8 full readback");
    rd_burst(NLOC - 2, 4, "R7 read wrap");

    wr_burst(16, 4, 77);
    rd_burst(14, 8, "R5 write without flag");

    cmd(8'h06);
    wr_status(8'hFF);
    rd_status("R3 R4 status write 0xFF");
    cmd(8'h06);
    wr_burst(0, 4, 123);
    rd_burst(0, 4, "R9 code 11 fences all");

    cmd(8'h06);
    wr_status(8'h04);
    rd_status("R1 code 01");
    cmd(8'h06);
    wr_burst((NLOC * 3) / 4 - 4, 8, 99);
    rd_burst((NLOC * 3) / 4 - 6, 12, "R9 R10 quarter boundary");
    cmd(8'h06);
    wr_burst(NLOC - 2, 4, 5);
    rd_burst(NLOC - 2, 4, "R10 abort holds across wrap");

    cmd(8'h06);
    wr_status(8'h08);
    cmd(8'h06);
    wr_burst(NLOC / 2 - 4, 8, 41);
    rd_burst(NLOC / 2 - 6, 12, "R9 R10 half boundary");
    cmd(8'h06);
    wr_burst(32, 4, 200);
    rd_burst(32, 4, "R9 unfenced low area");

    cmd(8'h06);
    wr_status(8'h00);
    sel();
    xfer(8'hAB, r);
    xfer(8'h06, r);
    xfer(8'h02, r);
    desel();
    rd_status("R11 unknown command");
    cmd(8'h06);
    sel();
    xfer(8'h9C, r);
    xfer(8'h01, r);
    xfer(8'h0C, r);
    desel();
    rd_status("R11 unknown keeps flag and code");
    cmd(8'h04);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1900000ns;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule